// File: doc/BRIEF.md
# Password-Gated Secondary Flash Lock Register

This block holds a second set of program/erase lock bits for the blocks of a flash array: one lock for the test/shadow region and one lock for each low/mid block. A bus master writes it as a 32-bit word. Each byte lane has its own enable. The master reads the word back from a combinational read port.

None of the lock bits can change until software has written a fixed unlock key as one whole word. That key write raises a status flag, and the flag stays high until the next reset. The test/shadow lock has two more restrictions. It is frozen from the moment the flash controller starts an interlocked program/erase operation until that operation reports done. It is also frozen while a high-voltage operation is suspended.

At reset the lock bits are loaded from configuration inputs that model fuse contents. Each lock is ORed with the matching bit of a primary lock register to drive the effective lock outputs. Erase of the test region is always reported as locked.

Top module: `flash_auxlock_top`

## Requirements
- R1: The unlock flag is read at rdData[31]. A write sets it only when byteEn is 4'hF and wrData is exactly 32'hC3C3_3333. Any other value, or any partial byte mask, leaves the flag as it was.
- R2: Once the unlock flag is set, it stays set until reset. No write can clear it.
- R3: While the unlock flag is 0, a write leaves rdData[20] (the shadow lock) and rdData[NUM_BLK-1:0] (the block locks) unchanged.
- R4: While the unlock flag is 1, a write with byteEn[2]=1 loads wrData[20] into the shadow lock. Block lock i loads wrData[i] when byteEn[i/8]=1. Lanes that are not enabled keep their values.
- R5: rdData bits 30..21 and 19..NUM_BLK read as 0 and ignore writes.
- R6: The shadow lock ignores writes from the cycle opStart is high until the cycle after the first cycle in which opDone is high. The block locks stay writable during this time.
- R7: The shadow lock ignores writes in every cycle in which opSuspended is high.
- R8: While rstN is low, the shadow lock loads cfgShadowLock, the block locks load cfgBlkLock, and the unlock flag clears. All-ones configuration inputs therefore give a fully locked state.
- R9: effShadowLock equals the shadow lock OR priShadowLock. effBlkLock[i] equals block lock i OR priBlkLock[i].
- R10: A write that sets the unlock flag (R1) changes no lock bit in that same cycle, even when the flag was already set.
- R11: effShadowEraseLock is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| byteEn | input | 4 | Byte lane enables for the write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Register read value |
| opStart | input | 1 | Pulse: interlock write started a program/erase |
| opDone | input | 1 | Controller done flag |
| opSuspended | input | 1 | High-voltage operation suspended |
| cfgShadowLock | input | 1 | Reset value of the shadow lock |
| cfgBlkLock | input | NUM_BLK | Reset values of the block locks |
| priShadowLock | input | 1 | Primary shadow lock bit |
| priBlkLock | input | NUM_BLK | Primary block lock bits |
| effShadowLock | output | 1 | Effective program lock, shadow region |
| effShadowEraseLock | output | 1 | Effective erase lock, test region |
| effBlkLock | output | NUM_BLK | Effective program locks, blocks |

## Verification
The bench builds the block with the default NUM_BLK of 16, so both block byte lanes are present. At that size every one of the 16 byte-enable masks can be swept against several data patterns, both with the unlock flag clear and with it set. Each write is checked against a full 32-bit read image that the bench computes. The freeze windows, the key write on its own and with partial masks, and the OR with the primary bits are then swept with the same model.

// File: rtl/flash_auxlock_pkg.sv
package flash_auxlock_pkg;
  localparam int DATA_W     = 32;
  localparam int LANE_W     = 8;
  localparam int NUM_LANES  = DATA_W / LANE_W;
  localparam int ENABLE_BIT = DATA_W - 1;      // MSB-first bit 0
  localparam int SHADOW_BIT = DATA_W - 1 - 11; // MSB-first bit 11
  localparam int SHADOW_LANE = SHADOW_BIT / LANE_W;
  localparam int MAX_BLK    = 16;
  localparam int BLK_LANES_MAX = MAX_BLK / LANE_W;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC3C3_3333;

  typedef struct packed {
    logic                     setEnable;
    logic                     shadowWr;
    logic [BLK_LANES_MAX-1:0] blkLaneWr;
  } lockStrobes_t;
endpackage

// File: rtl/flash_auxlock_ctrl.sv
module flash_auxlock_ctrl
  import flash_auxlock_pkg::*;
#(
  parameter int NUM_BLK = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [NUM_LANES-1:0] byteEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 opStart,
  input  logic                 opDone,
  input  logic                 opSuspended,
  output logic                 enFlag,
  output lockStrobes_t         strobes
);
  localparam int BLK_LANES = (NUM_BLK + LANE_W - 1) / LANE_W;

  logic keyHit;
  logic busyFlag;
  logic shadowFrozen;
  logic lockWrOk;

  assign keyHit = wrEn && (&byteEn) && (wrData == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enFlag <= 1'b0;
    end else if (keyHit) begin
      enFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyFlag <= 1'b0;
    end else if (opStart) begin
      busyFlag <= 1'b1;
    end else if (opDone) begin
      busyFlag <= 1'b0;
    end
  end

  assign shadowFrozen = busyFlag | opStart | opSuspended;
  assign lockWrOk     = wrEn && enFlag && !keyHit;

  always_comb begin
    strobes           = '0;
    strobes.setEnable = keyHit;
    strobes.shadowWr  = lockWrOk && byteEn[SHADOW_LANE] && !shadowFrozen;
    for (int l = 0; l < BLK_LANES; l++) begin
      strobes.blkLaneWr[l] = lockWrOk && byteEn[l];
    end
  end
endmodule

// File: rtl/flash_auxlock_dp.sv
module flash_auxlock_dp
  import flash_auxlock_pkg::*;
#(
  parameter int NUM_BLK = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  lockStrobes_t       strobes,
  input  logic               enFlag,
  input  logic               shadowIn,
  input  logic [NUM_BLK-1:0] blkIn,
  input  logic               cfgShadowLock,
  input  logic [NUM_BLK-1:0] cfgBlkLock,
  input  logic               priShadowLock,
  input  logic [NUM_BLK-1:0] priBlkLock,
  output logic [DATA_W-1:0]  rdData,
  output logic               effShadowLock,
  output logic               effShadowEraseLock,
  output logic [NUM_BLK-1:0] effBlkLock
);
  logic               shadowLock;
  logic [NUM_BLK-1:0] blkLock;
  logic               unusedSetEnable;

  assign unusedSetEnable = strobes.setEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowLock <= cfgShadowLock;
    end else if (strobes.shadowWr) begin
      shadowLock <= shadowIn;
    end
  end

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    localparam int LANE = i / LANE_W;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        blkLock[i] <= cfgBlkLock[i];
      end else if (strobes.blkLaneWr[LANE]) begin
        blkLock[i] <= blkIn[i];
      end
    end
  end

  always_comb begin
    rdData              = '0;
    rdData[ENABLE_BIT]  = enFlag;
    rdData[SHADOW_BIT]  = shadowLock;
    rdData[NUM_BLK-1:0] = blkLock;
  end

  assign effShadowLock      = shadowLock | priShadowLock;
  assign effShadowEraseLock = 1'b1 | unusedSetEnable;
  assign effBlkLock         = blkLock | priBlkLock;
endmodule

// File: rtl/flash_auxlock_top.sv
module flash_auxlock_top
  import flash_auxlock_pkg::*;
#(
  parameter int NUM_BLK = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [3:0]         byteEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic               opStart,
  input  logic               opDone,
  input  logic               opSuspended,
  input  logic               cfgShadowLock,
  input  logic [NUM_BLK-1:0] cfgBlkLock,
  input  logic               priShadowLock,
  input  logic [NUM_BLK-1:0] priBlkLock,
  output logic               effShadowLock,
  output logic               effShadowEraseLock,
  output logic [NUM_BLK-1:0] effBlkLock
);
  lockStrobes_t strobes;
  logic         enFlag;

  flash_auxlock_ctrl #(.NUM_BLK(NUM_BLK)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .byteEn      (byteEn),
    .wrData      (wrData),
    .opStart     (opStart),
    .opDone      (opDone),
    .opSuspended (opSuspended),
    .enFlag      (enFlag),
    .strobes     (strobes)
  );

  flash_auxlock_dp #(.NUM_BLK(NUM_BLK)) dp_i (
    .clk                (clk),
    .rstN               (rstN),
    .strobes            (strobes),
    .enFlag             (enFlag),
    .shadowIn           (wrData[SHADOW_BIT]),
    .blkIn              (wrData[NUM_BLK-1:0]),
    .cfgShadowLock      (cfgShadowLock),
    .cfgBlkLock         (cfgBlkLock),
    .priShadowLock      (priShadowLock),
    .priBlkLock         (priBlkLock),
    .rdData             (rdData),
    .effShadowLock      (effShadowLock),
    .effShadowEraseLock (effShadowEraseLock),
    .effBlkLock         (effBlkLock)
  );
endmodule

// File: rtl/flash_auxlock_chk.sv
module flash_auxlock_chk #(
  parameter int NUM_BLK = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [3:0]         byteEn,
  input logic [31:0]        wrData,
  input logic [31:0]        rdData,
  input logic               opStart,
  input logic               opDone,
  input logic               opSuspended,
  input logic               priShadowLock,
  input logic [NUM_BLK-1:0] priBlkLock,
  input logic               effShadowLock,
  input logic               effShadowEraseLock,
  input logic [NUM_BLK-1:0] effBlkLock
);
  logic keyWrite;
  logic busyMirror;
  logic [31:0] rsvdMask;

  assign keyWrite = wrEn && (byteEn == 4'hF) && (wrData == 32'hC3C3_3333);

  always_comb begin
    rsvdMask              = 32'hFFFF_FFFF;
    rsvdMask[31]          = 1'b0;
    rsvdMask[20]          = 1'b0;
    rsvdMask[NUM_BLK-1:0] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyMirror <= 1'b0;
    else if (opStart) busyMirror <= 1'b1;
    else if (opDone) busyMirror <= 1'b0;
  end

  p_key_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    keyWrite |=> rdData[31]);

  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31] |=> rdData[31]);

  p_locked_ignores_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[31] |=> ($stable(rdData[20]) && $stable(rdData[NUM_BLK-1:0])));

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & rsvdMask) == 32'h0);

  p_busy_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busyMirror || opStart) |=> $stable(rdData[20]));

  p_suspend_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    opSuspended |=> $stable(rdData[20]));

  p_eff_or_r9: assert property (@(posedge clk) disable iff (!rstN)
    (effShadowLock == (rdData[20] | priShadowLock)) &&
    (effBlkLock == (rdData[NUM_BLK-1:0] | priBlkLock)));

  p_key_no_update_r10: assert property (@(posedge clk) disable iff (!rstN)
    keyWrite |=> ($stable(rdData[20]) && $stable(rdData[NUM_BLK-1:0])));

  p_erase_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    effShadowEraseLock);
endmodule

bind flash_auxlock_top flash_auxlock_chk #(.NUM_BLK(NUM_BLK)) chk_i (.*);

// File: tb/flash_auxlock_top_tb_top.sv
module flash_auxlock_top_tb_top;
  localparam int NB = 16;
  localparam logic [31:0] KEY = 32'hC3C3_3333;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [3:0]    byteEn = 4'h0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic          opStart = 1'b0;
  logic          opDone = 1'b0;
  logic          opSuspended = 1'b0;
  logic          cfgShadowLock = 1'b1;
  logic [NB-1:0] cfgBlkLock = 16'hA5C3;
  logic          priShadowLock = 1'b0;
  logic [NB-1:0] priBlkLock = '0;
  logic          effShadowLock;
  logic          effShadowEraseLock;
  logic [NB-1:0] effBlkLock;

  int checks = 0;
  int failures = 0;
  logic          expEn;
  logic          expShadow;
  logic [NB-1:0] expBlk;

  always #2 clk = ~clk;

  flash_auxlock_top #(.NUM_BLK(NB)) dut_i (.*);

  function automatic logic [31:0] image();
    logic [31:0] v;
    v = '0;
    v[31] = expEn;
    v[20] = expShadow;
    v[NB-1:0] = expBlk;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; byteEn = be;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; byteEn = '0;
  endtask

  task automatic modelWrite(input logic [31:0] d, input logic [3:0] be, input logic frozen);
    if (be == 4'hF && d == KEY) begin
      expEn = 1'b1;
    end else if (expEn) begin
      if (be[2] && !frozen) expShadow = d[20];
      for (int i = 0; i < NB; i++) if (be[i/8]) expBlk[i] = d[i];
    end
  endtask

  task automatic applyReset(input logic cs, input logic [NB-1:0] cb);
    @(negedge clk);
    cfgShadowLock = cs; cfgBlkLock = cb; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expEn = 1'b0; expShadow = cs; expBlk = cb;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'h5A5A_A5A5;
    pats[3] = 32'h7FEF_1234; pats[4] = 32'hC3C3_3332; pats[5] = 32'h0010_8001;

    // R8 reset load, R5 reserved zero, R11 erase lock
    applyReset(1'b1, 16'hA5C3);
    chk("R8 reset image", rdData, image());
    chk("R11 erase lock", {31'b0, effShadowEraseLock}, 32'h1);

    // R3: every mask and pattern ignored while locked; R1 non-key values
    for (int be = 0; be < 16; be++) begin
      for (int p = 0; p < 6; p++) begin
        doWrite(pats[p], be[3:0]);
        chk("R3 locked write ignored", rdData, image());
      end
    end
    // R1: key with partial masks does not unlock
    for (int be = 0; be < 15; be++) begin
      doWrite(KEY, be[3:0]);
      chk("R1 partial key ignored", rdData, image());
    end

    // R1 + R10: full key unlocks, locks untouched
    doWrite(KEY, 4'hF);
    modelWrite(KEY, 4'hF, 1'b0);
    chk("R1/R10 key unlocks only", rdData, image());

    // R4, R5, R2: sweep masks and patterns while unlocked
    for (int be = 0; be < 16; be++) begin
      for (int p = 0; p < 6; p++) begin
        doWrite(pats[p], be[3:0]);
        modelWrite(pats[p], be[3:0], 1'b0);
        chk("R4 unlocked write", rdData, image());
      end
    end
    chk("R2 flag still set", {31'b0, rdData[31]}, 32'h1);

    // R10 key again while unlocked
    doWrite(KEY, 4'hF);
    chk("R10 repeat key no update", rdData, image());

    // R6: interlock window
    doWrite(32'h0000_0000, 4'hF); modelWrite(32'h0, 4'hF, 1'b0);
    @(negedge clk);
    opStart = 1'b1; wrEn = 1'b1; wrData = 32'h0010_FFFF; byteEn = 4'hF;
    @(negedge clk);
    opStart = 1'b0; wrEn = 1'b0; wrData = '0; byteEn = '0;
    modelWrite(32'h0010_FFFF, 4'hF, 1'b1);
    chk("R6 frozen at start, blocks written", rdData, image());
    doWrite(32'h0010_0F0F, 4'hF); modelWrite(32'h0010_0F0F, 4'hF, 1'b1);
    chk("R6 frozen while busy", rdData, image());
    @(negedge clk);
    opDone = 1'b1; wrEn = 1'b1; wrData = 32'h0010_0000; byteEn = 4'h4;
    @(negedge clk);
    opDone = 1'b0; wrEn = 1'b0; wrData = '0; byteEn = '0;
    chk("R6 frozen in done cycle", rdData, image());
    doWrite(32'h0010_0000, 4'h4); modelWrite(32'h0010_0000, 4'h4, 1'b0);
    chk("R6 writable after done", rdData, image());

    // R7: suspension
    opSuspended = 1'b1;
    doWrite(32'h0000_0000, 4'h4); modelWrite(32'h0, 4'h4, 1'b1);
    chk("R7 frozen while suspended", rdData, image());
    opSuspended = 1'b0;
    doWrite(32'h0000_0000, 4'h4); modelWrite(32'h0, 4'h4, 1'b0);
    chk("R7 writable after resume", rdData, image());

    // R9: OR with primary bits
    for (int s = 0; s < 2; s++) begin
      doWrite({11'b0, s[0], 4'b0, 16'h3C96}, 4'hF);
      modelWrite({11'b0, s[0], 4'b0, 16'h3C96}, 4'hF, 1'b0);
      for (int ps = 0; ps < 2; ps++) begin
        for (int pb = 0; pb < 4; pb++) begin
          @(negedge clk);
          priShadowLock = ps[0];
          priBlkLock = (pb == 0) ? 16'h0000 : (pb == 1) ? 16'hFFFF :
                       (pb == 2) ? 16'h5A01 : 16'h8421;
          #1;
          chk("R9 shadow eff", {31'b0, effShadowLock}, {31'b0, expShadow | ps[0]});
          chk("R9 block eff", {16'b0, effBlkLock}, {16'b0, expBlk | priBlkLock});
          chk("R11 erase lock", {31'b0, effShadowEraseLock}, 32'h1);
        end
      end
    end

    // R8 + R2: erased configuration reset clears flag, locks all
    applyReset(1'b1, 16'hFFFF);
    chk("R8 erased config locked", rdData, image());
    doWrite(32'h0, 4'hF);
    chk("R2/R3 flag cleared by reset", rdData, image());

    finishRun();
  end
endmodule